// File: doc/BRIEF.md
# OFDM Gray-Coded Constellation Mapper

The mapper sits between the bit interleaver and the subcarrier assembly stage of an OFDM transmitter. It accepts interleaved coded bits one at a time and gathers them into groups whose size depends on the selected modulation order. Each completed group is turned into one complex constellation point. The point is presented as signed fixed-point in-phase and quadrature words, together with a one-cycle valid strobe.

Four modulation orders are supported: BPSK, QPSK, 16-QAM and 64-QAM. Every axis amplitude uses Gray-ordered levels and is scaled so that the mean energy of each mode is one. The in-phase and quadrature amplitudes come from two separate constant tables, each addressed by the mode and the axis sub-field of the group. The modulation order is captured on a symbol-start pulse and is held for the rest of the OFDM symbol. An OFDM symbol holds 48 data points, so it carries 48, 96, 192 or 288 coded bits.

Top module: `qam_mapper`

## Requirements
- R1: While `rst_ni` is low and after its release, `valid_o`, `i_o` and `q_o` are 0 and the captured mode is BPSK.
- R2: Mode encoding on `mode_i` is 0 = BPSK, 1 = QPSK, 2 = 16-QAM, 3 = 64-QAM, with 1, 2, 4 and 6 bits per group. The first bit accepted is the most significant bit of the group. `valid_o` is high for exactly the one cycle that follows the cycle in which the last bit of a group was accepted, and is low in all other cycles.
- R3: In BPSK, bit 0 gives I = -16384 and bit 1 gives I = +16384, with Q = 0 (Q1.14, 1.0 = 16384).
- R4: In QPSK, the first bit selects I and the second bit selects Q. A 0 gives -11585 and a 1 gives +11585.
- R5: In 16-QAM, the first two bits select I and the last two select Q. Codes 00, 01, 11, 10 give -15543, -5181, +5181, +15543.
- R6: In 64-QAM, the first three bits select I and the last three select Q. Codes 000, 001, 011, 010, 110, 111, 101, 100 give -17697, -12641, -7584, -2528, +2528, +7584, +12641, +17697.
- R7: `mode_i` is captured only in a cycle where `sym_start_i` is high and no partial group is held. That mode applies to a bit accepted in the same cycle. At all other times the value on `mode_i` has no effect.
- R8: A `sym_start_i` pulse that arrives while a partial group is held is ignored. The group completes with its original mode and bit count.
- R9: A cycle with `bit_valid_i` low accepts no bit and does not advance the group. Such gaps may fall anywhere inside a group.
- R10: Between valid strobes, `i_o` and `q_o` hold the most recent point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_start_i | input | 1 | Symbol-start pulse; captures `mode_i` at a group boundary |
| mode_i | input | 2 | Modulation order (0 BPSK, 1 QPSK, 2 16-QAM, 3 64-QAM) |
| bit_valid_i | input | 1 | `bit_i` carries a coded bit this cycle |
| bit_i | input | 1 | Serial coded bit |
| valid_o | output | 1 | Constellation point valid (one-cycle pulse) |
| i_o | output | 16 | In-phase amplitude, signed Q1.14 |
| q_o | output | 16 | Quadrature amplitude, signed Q1.14 |

## Verification
Each point is due in the single cycle after the edge that accepts the final bit of its group. This holds even for BPSK, where the group has only one bit and the mode is captured at that same edge. The bench drives inputs on the falling edge and updates its behavioural model at once. After the following rising edge it compares `valid_o` and the point words, so every clock is checked against the model's prediction for that exact cycle. In cycles without a strobe, it checks that the previous point is held. Mid-group mode changes, gaps in `bit_valid_i` and symbol-start pulses that arrive at the wrong time are folded into the model, so any shift by one cycle or wrong grouping shows up as a mismatch in that cycle.

// File: rtl/qmap_pkg.sv
package qmap_pkg;

  typedef enum logic [1:0] {
    MOD_BPSK  = 2'd0,
    MOD_QPSK  = 2'd1,
    MOD_QAM16 = 2'd2,
    MOD_QAM64 = 2'd3
  } mod_e;

  localparam int GRP_MAX = 6;
  localparam int CNT_W   = $clog2(GRP_MAX);

  function automatic int unsigned grp_bits(mod_e m);
    case (m)
      MOD_BPSK:  return 1;
      MOD_QPSK:  return 2;
      MOD_QAM16: return 4;
      default:   return 6;
    endcase
  endfunction

  function automatic longint unsigned isqrt(longint unsigned x);
    longint unsigned rem = x;
    longint unsigned res = 0;
    longint unsigned b   = 64'd1 << 62;
    for (int k = 0; k < 32; k++) begin
      if (rem >= res + b) begin
        rem = rem - (res + b);
        res = (res >> 1) + b;
      end else begin
        res = res >> 1;
      end
      b = b >> 2;
    end
    return res;
  endfunction

  // round(k * 2^frac / sqrt(n)), k > 0
  function automatic int scaled_level(int k, int n, int frac);
    longint unsigned x;
    longint unsigned s;
    x = (longint'(k * k) << (2 * frac + 2)) / longint'(n);
    s = isqrt(x);
    return int'((s + 1) >> 1);
  endfunction

  function automatic logic [2:0] gray2bin3(logic [2:0] g);
    logic [2:0] b;
    b[2] = g[2];
    b[1] = b[2] ^ g[1];
    b[0] = b[1] ^ g[0];
    return b;
  endfunction

  function automatic int axis_level(bit q_axis, mod_e m, logic [2:0] code, int frac);
    int idx;
    int lvl;
    int mag;
    case (m)
      MOD_BPSK: begin
        if (q_axis) return 0;
        mag = scaled_level(1, 1, frac);
        return code[0] ? mag : -mag;
      end
      MOD_QPSK: begin
        mag = scaled_level(1, 2, frac);
        return code[0] ? mag : -mag;
      end
      MOD_QAM16: begin
        idx = int'(gray2bin3({1'b0, code[1:0]}));
        lvl = 2 * idx - 3;
        mag = scaled_level(lvl < 0 ? -lvl : lvl, 10, frac);
        return lvl < 0 ? -mag : mag;
      end
      default: begin
        idx = int'(gray2bin3(code));
        lvl = 2 * idx - 7;
        mag = scaled_level(lvl < 0 ? -lvl : lvl, 42, frac);
        return lvl < 0 ? -mag : mag;
      end
    endcase
  endfunction

endpackage

// File: rtl/qmap_bit_collector.sv
module qmap_bit_collector
  import qmap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sym_start_i,
  input  logic [1:0]         mode_i,
  input  logic               bit_valid_i,
  input  logic               bit_i,
  output logic               grp_done_o,
  output logic [GRP_MAX-1:0] grp_o,
  output mod_e               grp_mode_o
);

  logic [CNT_W-1:0]   cnt_q;
  logic [GRP_MAX-2:0] sh_q;
  mod_e               mode_q;
  mod_e               eff_mode;
  logic               at_boundary;
  logic               take_mode;
  int unsigned        need;

  assign at_boundary = (cnt_q == '0);
  assign take_mode   = sym_start_i && at_boundary;
  assign eff_mode    = take_mode ? mod_e'(mode_i) : mode_q;
  assign need        = grp_bits(eff_mode);
  assign grp_o       = {sh_q, bit_i};
  assign grp_done_o  = bit_valid_i && (cnt_q == CNT_W'(need - 1));
  assign grp_mode_o  = eff_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      mode_q <= MOD_BPSK;
    end else begin
      if (take_mode) mode_q <= eff_mode;
      if (bit_valid_i) begin
        sh_q  <= grp_o[GRP_MAX-2:0];
        cnt_q <= grp_done_o ? '0 : cnt_q + 1'b1;
      end
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(grp_bits(mode_q)));

  p_mode_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sym_start_i && cnt_q == '0) |=> $stable(mode_q));

  p_gap_no_advance_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> $stable(cnt_q));

endmodule

// File: rtl/qmap_level_lut.sv
module qmap_level_lut
  import qmap_pkg::*;
#(
  parameter bit Q_AXIS = 1'b0,
  parameter int DW     = 16,
  parameter int FRAC   = 14
) (
  input  mod_e                 mode_i,
  input  logic [2:0]           code_i,
  output logic signed [DW-1:0] level_o
);

  localparam int ENTRIES = 4 * 8;

  logic signed [DW-1:0] tbl [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_tbl
    assign tbl[e] = DW'(axis_level(Q_AXIS, mod_e'(2'(e >> 3)), 3'(e), FRAC));
  end

  assign level_o = tbl[{mode_i, code_i}];

endmodule

// File: rtl/qam_mapper.sv
module qam_mapper
  import qmap_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sym_start_i,
  input  logic [1:0]           mode_i,
  input  logic                 bit_valid_i,
  input  logic                 bit_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] i_o,
  output logic signed [DW-1:0] q_o
);

  logic               grp_done;
  logic [GRP_MAX-1:0] grp;
  mod_e               grp_mode;
  logic [2:0]         i_code;
  logic [2:0]         q_code;
  logic signed [DW-1:0] i_lvl;
  logic signed [DW-1:0] q_lvl;
  logic                 valid_q;
  logic signed [DW-1:0] i_q;
  logic signed [DW-1:0] q_q;
  mod_e                 out_mode_q;

  qmap_bit_collector u_coll (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_start_i (sym_start_i),
    .mode_i      (mode_i),
    .bit_valid_i (bit_valid_i),
    .bit_i       (bit_i),
    .grp_done_o  (grp_done),
    .grp_o       (grp),
    .grp_mode_o  (grp_mode)
  );

  // split group into per-axis sub-fields, MSB first
  always_comb begin
    case (grp_mode)
      MOD_BPSK:  begin i_code = {2'b00, grp[0]};   q_code = 3'b000; end
      MOD_QPSK:  begin i_code = {2'b00, grp[1]};   q_code = {2'b00, grp[0]}; end
      MOD_QAM16: begin i_code = {1'b0, grp[3:2]};  q_code = {1'b0, grp[1:0]}; end
      default:   begin i_code = grp[5:3];          q_code = grp[2:0]; end
    endcase
  end

  qmap_level_lut #(.Q_AXIS(1'b0), .DW(DW), .FRAC(FRAC)) u_lut_i (
    .mode_i  (grp_mode),
    .code_i  (i_code),
    .level_o (i_lvl)
  );

  qmap_level_lut #(.Q_AXIS(1'b1), .DW(DW), .FRAC(FRAC)) u_lut_q (
    .mode_i  (grp_mode),
    .code_i  (q_code),
    .level_o (q_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      i_q        <= '0;
      q_q        <= '0;
      out_mode_q <= MOD_BPSK;
    end else begin
      valid_q <= grp_done;
      if (grp_done) begin
        i_q        <= i_lvl;
        q_q        <= q_lvl;
        out_mode_q <= grp_mode;
      end
    end
  end

  assign valid_o = valid_q;
  assign i_o     = i_q;
  assign q_o     = q_q;

  p_valid_after_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_valid_i));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(i_o) && $stable(q_o)));

  p_bpsk_q_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && out_mode_q == MOD_BPSK) |-> (q_o == '0));

  p_i_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (i_o != '0));

endmodule

// File: tb/sim_qam_mapper.sv
module sim_qam_mapper;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sym_start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic valid_o;
  logic signed [15:0] i_o;
  logic signed [15:0] q_o;

  always #10 clk = ~clk;

  qam_mapper u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sym_start_i (sym_start),
    .mode_i      (mode),
    .bit_valid_i (bit_valid),
    .bit_i       (bit_in),
    .valid_o     (valid_o),
    .i_o         (i_o),
    .q_o         (q_o)
  );

  int checks = 0;
  int errors = 0;
  string scen = "R1";

  // reference model state
  int m_mode = 0;
  int m_cnt = 0;
  int m_acc = 0;
  bit exp_v = 0;
  int exp_i = 0;
  int exp_q = 0;
  int last_i = 0;
  int last_q = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int rnd(real x);
    if (x >= 0.0) return $rtoi(x * 16384.0 + 0.5);
    return -$rtoi(-x * 16384.0 + 0.5);
  endfunction

  function automatic int lvl16(int c);
    int t[4] = '{-3, -1, 3, 1};
    return t[c];
  endfunction

  function automatic int lvl64(int c);
    int t[8] = '{-7, -5, -1, -3, 7, 5, 1, 3};
    return t[c];
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] act=%0d exp=%0d at %0t", req, scen, act, expv, $time);
    end
  endtask

  function automatic string mode_tag(int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic step(bit sym, int md, bit vld, bit b);
    int need;
    string tag;
    @(negedge clk);
    sym_start = sym;
    mode = 2'(md);
    bit_valid = vld;
    bit_in = b;
    if (sym && m_cnt == 0) m_mode = md;
    case (m_mode)
      0: need = 1;
      1: need = 2;
      2: need = 4;
      default: need = 6;
    endcase
    exp_v = 0;
    if (vld) begin
      m_acc = (m_acc << 1) | int'(b);
      m_cnt++;
      if (m_cnt == need) begin
        exp_v = 1;
        case (m_mode)
          0: begin exp_i = rnd((m_acc & 1) ? 1.0 : -1.0); exp_q = 0; end
          1: begin
            exp_i = rnd(((m_acc >> 1) & 1) ? 1.0 / $sqrt(2.0) : -1.0 / $sqrt(2.0));
            exp_q = rnd((m_acc & 1) ? 1.0 / $sqrt(2.0) : -1.0 / $sqrt(2.0));
          end
          2: begin
            exp_i = rnd(real'(lvl16((m_acc >> 2) & 3)) / $sqrt(10.0));
            exp_q = rnd(real'(lvl16(m_acc & 3)) / $sqrt(10.0));
          end
          default: begin
            exp_i = rnd(real'(lvl64((m_acc >> 3) & 7)) / $sqrt(42.0));
            exp_q = rnd(real'(lvl64(m_acc & 7)) / $sqrt(42.0));
          end
        endcase
        m_cnt = 0;
        m_acc = 0;
      end
    end
    tag = mode_tag(m_mode);
    @(posedge clk);
    #2;
    check(valid_o == exp_v, "R2", int'(valid_o), int'(exp_v));
    if (exp_v) begin
      check(int'(i_o) == exp_i, tag, int'(i_o), exp_i);
      check(int'(q_o) == exp_q, tag, int'(q_o), exp_q);
      last_i = exp_i;
      last_q = exp_q;
    end else begin
      check(int'(i_o) == last_i, "R10", int'(i_o), last_i);
      check(int'(q_o) == last_q, "R10", int'(q_o), last_q);
    end
  endtask

  task automatic send_word(int md, int val, int nb, bit first_sym);
    for (int k = nb - 1; k >= 0; k--)
      step(first_sym && k == nb - 1, md, 1'b1, 1'((val >> k) & 1));
  endtask

  task automatic lfsr_bit(output bit b);
    b = lfsr[0];
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    scen = "R1 reset";
    check(valid_o == 1'b0, "R1", int'(valid_o), 0);
    check(i_o == 16'sd0, "R1", int'(i_o), 0);
    check(q_o == 16'sd0, "R1", int'(q_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // default mode after reset is BPSK, no start pulse
    scen = "R1 default BPSK";
    step(0, 3, 1, 1);
    step(0, 2, 1, 0);
    step(0, 0, 0, 0);

    scen = "R4 QPSK codes";
    for (int c = 0; c < 4; c++) send_word(1, c, 2, c == 0);

    scen = "R5 16QAM codes";
    for (int c = 0; c < 16; c++) send_word(2, c, 4, c == 0);

    scen = "R9 64QAM codes with gaps";
    for (int c = 0; c < 64; c++)
      for (int k = 5; k >= 0; k--) begin
        step(c == 0 && k == 5, 3, 1, 1'((c >> k) & 1));
        if ((c + k) % 3 == 0) step(0, 0, 0, 0);
      end

    scen = "R7 mode_i toggles without start";
    for (int c = 0; c < 8; c++)
      for (int k = 5; k >= 0; k--) step(0, (c + k) & 3, 1, 1'((c * 7 >> k) & 1));

    scen = "R8 start mid-group";
    step(0, 3, 1, 1);
    step(0, 3, 1, 0);
    step(1, 0, 1, 1);
    step(1, 1, 0, 0);
    step(0, 0, 1, 1);
    step(1, 2, 1, 0);
    step(0, 0, 1, 1);

    scen = "R7 start at boundary without bit";
    step(1, 0, 0, 0);
    step(0, 3, 0, 0);
    step(0, 3, 1, 0);
    step(0, 3, 1, 1);

    scen = "R3 BPSK back-to-back";
    for (int k = 0; k < 6; k++) step(k == 0, 0, 1, 1'(k & 1));

    scen = "R6 full 64QAM symbol";
    for (int n = 0; n < 288; n++) begin
      bit b;
      lfsr_bit(b);
      step(n == 0, 3, 1, b);
    end

    scen = "R4 full QPSK symbol";
    for (int n = 0; n < 96; n++) begin
      bit b;
      lfsr_bit(b);
      step(n == 0, 1, 1, b);
    end

    scen = "R10 idle hold";
    for (int k = 0; k < 4; k++) step(0, k, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule